// File: doc/BRIEF.md
# Chainable Timer with Slave-Mode Control and Trigger Output

This block is an up-counting timer. A prescaler divides its count clock and a reload value sets its period. A slave-mode controller lets a trigger input reset the counter, gate it, start it or clock it. A trigger output carries one internal event, chosen by software, so that several instances can be wired in a chain. One timer's trigger output feeds the trigger lines of the next timer.

Software configures the timer through a write-only port of eight addressed words. The active trigger line is chosen from four external lines and synchronised inside the block. The counter value, a one-clock update-event pulse and the trigger output are visible at the ports.

Register map, addressed by `wr_addr`:
- Address 0, control word: bit 0 = run, bit 1 = reload preload enable, bits 4:2 = slave mode, bits 6:5 = trigger select, bits 9:7 = master mode.
- Address 1: prescaler value.
- Address 2: reload value.
- Address 3: event word. Writing 1 to bit 0 forces a software update.
- Addresses 4 to 7: compare values for channels 1 to 4.

Top module: `tmr_chain_ctrl`

## Requirements
- R1: After reset the counter reads 0, and both `upd_evt` and `trig_out` are low.
- R2: The update period is (reload+1)*(prescaler+1) clocks. When the counter reaches the reload value it wraps to 0, and `upd_evt` pulses for one clock in the cycle the counter shows 0. A newly written prescaler value takes effect only at the next update.
- R3: With preload enable set (control bit 1), a new reload value takes effect only at the next update. With preload enable clear, a new reload value takes effect immediately.
- R4: Writing 1 to bit 0 of address 3 forces an update on the next edge. The counter and prescaler are cleared, the buffered values are loaded, and `upd_evt` is high in the following cycle.
- R5: The trigger select field (control bits 6:5) picks `trig_in[sel]` through a two-flop synchroniser. The other lines have no effect.
- R6: In slave mode 4 (reset), a rising edge on the selected line clears the counter and raises `upd_evt` three clocks after the input rises. Counting then continues.
- R7: In slave mode 5 (gated), the counter advances only while the synchronised line is high and the run bit is set. When the line falls, the counter holds its value and is not cleared.
- R8: In slave mode 6 (trigger), a rising edge on the selected line sets the run bit without clearing the counter. The first increment comes four clocks after the input rises, and counting continues after the line falls.
- R9: In slave mode 7 (external clock), each rising edge of the selected line is one prescaler input event. The internal clock does not advance the counter.
- R10: In slave modes 0 to 3, the counter runs from the internal clock whenever the run bit is set, and holds when it is clear.
- R11: In master mode 0, `trig_out` pulses for one clock after a software update. In master mode 1, `trig_out` follows the counter-enable condition.
- R12: In master mode 2, `trig_out` equals `upd_evt`. In master mode 3, `trig_out` pulses for one clock in the cycle the counter takes the channel-1 compare value.
- R13: In master modes 4 to 7, `trig_out` is high while the counter is below the compare value of channel 1 to 4 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Register write data |
| trig_in | input | NTRG | Asynchronous external trigger lines |
| cnt_q | output | W | Counter value |
| upd_evt | output | 1 | One-clock update-event pulse |
| trig_out | output | 1 | Trigger output selected by master mode |

## Verification
Most internal faults appear at the ports within one period or within a few clocks of a trigger edge:
- A wrong buffered prescaler or reload value changes the spacing between `upd_evt` pulses in the very next period after an update.
- A broken synchroniser or edge detector shifts the reset and start responses away from their fixed three- and four-clock latencies.
- A gate or run bit stuck in the wrong state shows up as a counter that moves, or fails to move, within one clock.

Compare faults are visible only through `trig_out`, so each master-mode reference is checked by counting its high cycles over two full periods.

// File: rtl/tmr_chain_ctrl.sv
module tmr_chain_ctrl #(
  parameter int W    = 16,
  parameter int NTRG = 4,
  parameter int NCH  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic [NTRG-1:0] trig_in,
  output logic [W-1:0]    cnt_q,
  output logic            upd_evt,
  output logic            trig_out
);
  localparam logic [2:0] A_CTRL = 3'd0, A_PSC = 3'd1, A_ARR = 3'd2, A_EVT = 3'd3;
  localparam logic [2:0] SM_RST = 3'd4, SM_GATE = 3'd5, SM_TRIG = 3'd6, SM_EXT = 3'd7;

  logic            run_q, arpe_q;
  logic [2:0]      smode_q, mmode_q;
  logic [1:0]      sel_q;
  logic [W-1:0]    psc_reg, psc_sh, arr_reg, arr_sh, psc_cnt, cnt_nxt, arr_eff;
  logic [W-1:0]    cmp_q [NCH];
  logic [NTRG-1:0] sync1, sync2;
  logic            trgi_s, trgi_d, trg_rise, cnt_en, src, psc_hit, tick, wrap;
  logic            rst_evt, upd, ug_q, cc_q, wr_ctrl, sw_ug;
  logic [NCH-1:0]  oc_ref;

  assign wr_ctrl  = wr_en && wr_addr == A_CTRL;
  assign sw_ug    = wr_en && wr_addr == A_EVT && wr_data[0];
  assign trgi_s   = sync2[sel_q];
  assign trg_rise = trgi_s && !trgi_d;
  assign cnt_en   = run_q && (smode_q != SM_GATE || trgi_s);
  assign src      = (smode_q == SM_EXT) ? trg_rise : 1'b1;
  assign psc_hit  = psc_cnt == psc_sh;
  assign tick     = cnt_en && src && psc_hit;
  assign arr_eff  = arpe_q ? arr_sh : arr_reg;
  assign wrap     = tick && cnt_q == arr_eff;
  assign rst_evt  = sw_ug || (smode_q == SM_RST && trg_rise);
  assign upd      = rst_evt || wrap;
  assign cnt_nxt  = upd ? '0 : (tick ? cnt_q + 1'b1 : cnt_q);
  assign upd_evt  = upd_q_out;

  logic upd_q_out;

  for (genvar i = 0; i < NCH; i++) begin : g_ref
    assign oc_ref[i] = cnt_q < cmp_q[i];
  end

  always_comb begin
    case (mmode_q)
      3'd0:    trig_out = ug_q;
      3'd1:    trig_out = cnt_en;
      3'd2:    trig_out = upd_q_out;
      3'd3:    trig_out = cc_q;
      default: trig_out = oc_ref[mmode_q[1:0]];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0; sync2 <= '0; trgi_d <= 1'b0;
      run_q <= 1'b0; arpe_q <= 1'b0; smode_q <= '0; mmode_q <= '0; sel_q <= '0;
      psc_reg <= '0; psc_sh <= '0; arr_reg <= '0; arr_sh <= '0;
      psc_cnt <= '0; cnt_q <= '0; upd_q_out <= 1'b0; ug_q <= 1'b0; cc_q <= 1'b0;
      for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
    end else begin
      sync1  <= trig_in;
      sync2  <= sync1;
      trgi_d <= trgi_s;
      if (wr_ctrl) begin
        run_q   <= wr_data[0];
        arpe_q  <= wr_data[1];
        smode_q <= wr_data[4:2];
        sel_q   <= wr_data[6:5];
        mmode_q <= wr_data[9:7];
      end else if (smode_q == SM_TRIG && trg_rise) begin
        run_q <= 1'b1;
      end
      if (wr_en && wr_addr == A_PSC) psc_reg <= wr_data;
      if (wr_en && wr_addr == A_ARR) arr_reg <= wr_data;
      for (int i = 0; i < NCH; i++)
        if (wr_en && wr_addr == 3'(4 + i)) cmp_q[i] <= wr_data;
      if (upd) begin
        psc_sh <= psc_reg;
        arr_sh <= arr_reg;
      end
      if (rst_evt)            psc_cnt <= '0;
      else if (cnt_en && src) psc_cnt <= psc_hit ? '0 : psc_cnt + 1'b1;
      cnt_q     <= cnt_nxt;
      upd_q_out <= upd;
      ug_q      <= sw_ug;
      cc_q      <= tick && cnt_nxt == cmp_q[0];
    end
  end

  p_upd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q_out |-> cnt_q == '0);

  p_gate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smode_q == SM_GATE && !trgi_s && !wr_en) |=> $stable(cnt_q));

  p_reset_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smode_q == SM_RST && trg_rise && !wr_en) |=> (cnt_q == '0 && upd_q_out));

  p_ext_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smode_q == SM_EXT && !trg_rise && !wr_en) |=> $stable(cnt_q));

  p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && smode_q != SM_RST && smode_q != SM_TRIG && !wr_en) |=> $stable(cnt_q));

  p_start_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (smode_q == SM_TRIG && trg_rise && !wr_en) |=> run_q);
endmodule

// File: tb/test_tmr_chain_ctrl.sv
module test_tmr_chain_ctrl;
  localparam int W = 16;
  localparam int K_CNT = 0, K_UPD = 1, K_TRGO = 2, K_GAP = 3, K_HIGH = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [3:0]   trig_in = '0;
  logic [W-1:0] cnt_q;
  logic         upd_evt, trig_out;

  tmr_chain_ctrl #(.W(W)) i_tmr_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_in(trig_in), .cnt_q(cnt_q), .upd_evt(upd_evt), .trig_out(trig_out)
  );

  always #4 clk = ~clk;

  typedef struct { int kind; int req; int exp; } item_t;
  item_t q[$];
  bit    busy = 1'b0;
  int    total = 0, bad = 0;
  bit    done = 1'b0;

  function automatic logic [W-1:0] ctl(input bit run, input bit arpe, input int sm,
                                       input int sel, input int mm);
    return W'({mm[2:0], sel[1:0], sm[2:0], arpe, run});
  endfunction

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_item(input int kind, input int req, input int exp);
    item_t it;
    it.kind = kind; it.req = req; it.exp = exp;
    q.push_back(it);
    wait (q.size() == 0 && !busy);
  endtask

  task automatic wait_upd();
    do @(negedge clk); while (!upd_evt);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      item_t it;
      int act;
      wait (q.size() > 0);
      busy = 1'b1;
      it = q.pop_front();
      case (it.kind)
        K_CNT:  act = int'(cnt_q);
        K_UPD:  act = int'(upd_evt);
        K_TRGO: act = int'(trig_out);
        K_GAP: begin
          act = 0;
          do begin @(negedge clk); act++; end while (!upd_evt && act < 100);
        end
        default: begin
          act = 0;
          for (int i = 0; i < 12; i++) begin @(negedge clk); act += int'(trig_out); end
        end
      endcase
      total++;
      if (act != it.exp) begin
        bad++;
        $display("FAIL R%0d kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
      end
      busy = 1'b0;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    int c;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    expect_item(K_CNT, 1, 0);
    expect_item(K_UPD, 1, 0);
    expect_item(K_TRGO, 1, 0);

    // R2 period and buffered prescaler, master mode 2 (R12)
    wr(1, 1); wr(2, 3); wr(3, 1);
    wr(0, ctl(1, 0, 0, 0, 2));
    wait_upd();
    expect_item(K_TRGO, 12, 1);
    expect_item(K_GAP, 2, 8);
    wait_upd();
    wr(1, 3);
    expect_item(K_GAP, 2, 7);
    expect_item(K_GAP, 2, 16);
    wr(1, 0); wr(3, 1);

    // R3 preload enabled: new reload waits for the next update
    wr(0, ctl(0, 1, 0, 0, 2)); wr(2, 3); wr(3, 1);
    wr(0, ctl(1, 1, 0, 0, 2));
    wait_upd();
    wr(2, 7);
    expect_item(K_GAP, 3, 3);
    expect_item(K_GAP, 3, 8);
    // R3 preload disabled: new reload applies at once
    wr(2, 3); wr(0, ctl(1, 0, 0, 0, 2)); wr(3, 1);
    wait_upd();
    wr(2, 7);
    expect_item(K_GAP, 3, 7);

    // R4 software update while running
    wr(2, 200);
    idle(10);
    wr(3, 1);
    expect_item(K_CNT, 4, 0);
    expect_item(K_UPD, 4, 1);

    // R10 encoder code 2 behaves as internal clock, run bit stops it
    wr(0, ctl(1, 0, 2, 0, 2)); wr(3, 1);
    idle(5);
    expect_item(K_CNT, 10, 5);
    wr(0, ctl(0, 0, 2, 0, 2));
    idle(5);
    expect_item(K_CNT, 10, 6);

    // R7 gated mode on line 1
    wr(0, ctl(1, 0, 5, 1, 2)); wr(3, 1);
    idle(5);
    expect_item(K_CNT, 7, 0);
    trig_in[1] = 1'b1; idle(10); trig_in[1] = 1'b0;
    idle(6);
    expect_item(K_CNT, 7, 10);
    idle(5);
    expect_item(K_CNT, 7, 10);

    // R8 trigger mode on line 2: start without clearing
    wr(0, ctl(1, 0, 6, 2, 2));
    idle(4);
    wr(0, ctl(0, 0, 6, 2, 2));
    idle(3);
    c = int'(cnt_q);
    expect_item(K_CNT, 8, c);
    trig_in[2] = 1'b1; idle(8);
    expect_item(K_CNT, 8, c + 5);
    trig_in[2] = 1'b0; idle(10);
    expect_item(K_CNT, 8, c + 15);

    // R9 external clock on line 0, R5 line 1 ignored
    wr(0, ctl(1, 0, 7, 0, 2)); wr(3, 1);
    idle(5);
    expect_item(K_CNT, 9, 0);
    for (int i = 0; i < 5; i++) begin trig_in[0] = 1'b1; idle(2); trig_in[0] = 1'b0; idle(2); end
    idle(5);
    expect_item(K_CNT, 9, 5);
    for (int i = 0; i < 3; i++) begin trig_in[1] = 1'b1; idle(2); trig_in[1] = 1'b0; idle(2); end
    idle(5);
    expect_item(K_CNT, 5, 5);

    // R6 reset mode on line 3
    wr(0, ctl(1, 0, 4, 3, 2)); wr(3, 1);
    idle(30);
    trig_in[3] = 1'b1; idle(3);
    expect_item(K_CNT, 6, 0);
    expect_item(K_UPD, 6, 1);
    idle(5);
    expect_item(K_CNT, 6, 5);
    trig_in[3] = 1'b0;

    // R11 master mode 0: software update pulse
    wr(0, ctl(0, 0, 0, 0, 0));
    wr(3, 1);
    expect_item(K_TRGO, 11, 1);
    idle(1);
    expect_item(K_TRGO, 11, 0);
    // R11 master mode 1: counter enable
    wr(0, ctl(1, 0, 0, 0, 1));
    expect_item(K_TRGO, 11, 1);
    wr(0, ctl(0, 0, 0, 0, 1));
    expect_item(K_TRGO, 11, 0);

    // R12 master mode 3: compare pulse on channel 1
    wr(2, 5); wr(4, 2);
    wr(0, ctl(1, 0, 0, 0, 3)); wr(3, 1);
    do @(negedge clk); while (!trig_out);
    expect_item(K_CNT, 12, 2);
    idle(1);
    expect_item(K_TRGO, 12, 0);

    // R13 compare references: channel 2 value 3, channel 4 value 0
    wr(5, 3); wr(7, 0);
    wr(0, ctl(1, 0, 0, 0, 5));
    expect_item(K_HIGH, 13, 6);
    wr(0, ctl(1, 0, 0, 0, 7));
    expect_item(K_HIGH, 13, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule